// File: doc/BRIEF.md
# Dual-Speed Single-Wire Slave Bit Interface

This block is the physical layer of a slave on a single-wire, open-drain bus. It oversamples the shared data line with a free-running clock. It finds bus resets and answers each one with a presence pulse. It decodes host write slots into bits and packs them into bytes, least significant bit first. When the layer above asks for it, the block answers host read slots by pulling the line low for a zero. Every timing threshold is computed from the `CLK_HZ` parameter.

Two timing sets are built in: standard speed, for roughly 16 kbit/s, and overdrive, for roughly 143 kbit/s. A mode input chooses between them while the block runs. The block samples the mode input, and the direction inputs, at the falling edge that opens each low pulse. That pulse is then timed and answered with those values until it ends, even if the inputs change during it. The layer above decodes commands, toggles the mode input, and supplies one data bit for each read slot.

Top module: `onewire_slave_phy`

## Requirements
- R1: While reset is asserted, and right after it is released, `dq_pull`, `bus_reset`, `slot_done` and `rx_valid` are all 0.
- R2: In standard mode, a low pulse of 480 µs or longer is a bus reset. `bus_reset` pulses for one clock after the line returns high. A 100 µs low pulse in standard mode is not a reset.
- R3: After a standard-mode reset, `dq_pull` first rises 15 to 60 µs after the line is released. It then stays high for 60 to 240 µs.
- R4: In overdrive mode, a low pulse of 48 µs or longer is a bus reset. The presence pull starts 2 to 6 µs after release and lasts 8 to 24 µs.
- R5: In a write slot (`tx_mode`=0), the bit is 0 if the line is still low at the decision point and 1 if it is high. The decision point is about 30 µs after the falling edge in standard mode and about 3 µs in overdrive.
- R6: After the eighth write bit, `rx_byte` presents the byte for one `rx_valid` pulse. The first bit received lands in bit 0. `rx_byte` changes only together with `rx_valid`.
- R7: In a read slot (`tx_mode`=1), `tx_bit`=0 makes the block pull the line low from shortly after the falling edge. It holds the pull for about 30 µs (standard) or 3 µs (overdrive), so a host sampling at 10 µs (standard) or 1.5 µs (overdrive) reads 0. `tx_bit`=1 leaves the line released, so the host reads 1.
- R8: Read slots add no bits to the byte under assembly. Write bits on either side of a run of read slots join into one byte.
- R9: A bus reset throws away the bits already collected for a byte. The next byte starts again at bit 0.
- R10: The mode and direction are latched at each falling edge. Changing `od_mode` during a low pulse does not change how that pulse is timed. A 60 µs pulse that begins in overdrive is still a reset.
- R11: Every completed bit slot, read or write, gives one `slot_done` pulse. A reset pulse gives none, and `bus_reset` and `slot_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock of `CLK_HZ` Hz |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq_in | input | 1 | Raw level of the open-drain data line |
| od_mode | input | 1 | 1 selects overdrive timing, 0 selects standard timing |
| tx_mode | input | 1 | 1 makes the next slot a read slot answered by the slave |
| tx_bit | input | 1 | Bit to present in the next read slot |
| dq_pull | output | 1 | 1 drives the data line low through the open-drain output |
| bus_reset | output | 1 | One-clock pulse after a detected bus reset |
| slot_done | output | 1 | One-clock pulse at the end of each bit slot |
| rx_byte | output | BYTE_W | Last assembled byte, least significant bit received first |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` is updated |

## Verification
The bench sends a 100 µs low pulse twice. In standard mode it must decode as a zero bit. In overdrive it must decode as a reset, and a design that compared against the wrong table would count a reset where a bit belongs, or the reverse. The bench switches `od_mode` in the middle of a pulse: a design that does not latch the mode would drop a reset it should see. Other tests place read slots in the middle of a byte, to catch a design that shifts in its own answer bits. They also place a reset after three bits, to catch a design that would misalign every later byte. The presence timing is measured against the windows of both speeds, so a swapped or unscaled threshold shows up as a pulse outside its window.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_PRES_WAIT,
    ST_PRES_LOW,
    ST_WAIT_HIGH
  } ow_state_e;

  // Clock cycles spanned by a duration given in tenths of a microsecond.
  function automatic int unsigned tenths_to_cycles(input int unsigned clk_hz,
                                                   input int unsigned tenths);
    return (clk_hz / 1_000_000) * tenths / 10;
  endfunction

endpackage

// File: rtl/onewire_sync.sv
module onewire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_raw,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  // Idle bus level is high, so every stage resets to 1.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/onewire_timing.sv
module onewire_timing #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int          CW     = 15
) (
  input  logic          od_sel,
  output logic [CW-1:0] t_reset,
  output logic [CW-1:0] t_pres_wait,
  output logic [CW-1:0] t_pres_low,
  output logic [CW-1:0] t_sample,
  output logic [CW-1:0] t_hold
);
  import onewire_pkg::*;

  // Standard-speed thresholds (tenths of a microsecond in the calls).
  localparam int unsigned STD_RESET = tenths_to_cycles(CLK_HZ, 4800);
  localparam int unsigned STD_PWAIT = tenths_to_cycles(CLK_HZ, 300);
  localparam int unsigned STD_PLOW  = tenths_to_cycles(CLK_HZ, 1200);
  localparam int unsigned STD_SMP   = tenths_to_cycles(CLK_HZ, 300);
  localparam int unsigned STD_HOLD  = tenths_to_cycles(CLK_HZ, 300);
  // Overdrive thresholds.
  localparam int unsigned OD_RESET  = tenths_to_cycles(CLK_HZ, 480);
  localparam int unsigned OD_PWAIT  = tenths_to_cycles(CLK_HZ, 30);
  localparam int unsigned OD_PLOW   = tenths_to_cycles(CLK_HZ, 120);
  localparam int unsigned OD_SMP    = tenths_to_cycles(CLK_HZ, 30);
  localparam int unsigned OD_HOLD   = tenths_to_cycles(CLK_HZ, 30);

  always_comb begin
    if (od_sel) begin
      t_reset     = CW'(OD_RESET);
      t_pres_wait = CW'(OD_PWAIT);
      t_pres_low  = CW'(OD_PLOW);
      t_sample    = CW'(OD_SMP);
      t_hold      = CW'(OD_HOLD);
    end else begin
      t_reset     = CW'(STD_RESET);
      t_pres_wait = CW'(STD_PWAIT);
      t_pres_low  = CW'(STD_PLOW);
      t_sample    = CW'(STD_SMP);
      t_hold      = CW'(STD_HOLD);
    end
  end
endmodule

// File: rtl/onewire_slot_ctrl.sv
module onewire_slot_ctrl #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic          od_mode,
  input  logic          tx_mode,
  input  logic          tx_bit,
  input  logic [CW-1:0] t_reset,
  input  logic [CW-1:0] t_pres_wait,
  input  logic [CW-1:0] t_pres_low,
  input  logic [CW-1:0] t_sample,
  input  logic [CW-1:0] t_hold,
  output logic          od_latched,
  output logic          pull,
  output logic          bus_rst,
  output logic          slot_end,
  output logic          bit_stb,
  output logic          bit_val
);
  import onewire_pkg::*;

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  ow_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;
  logic          mode_q, mode_n;
  logic          wr_q, wr_n;
  logic          drv0_q, drv0_n;
  logic          smp_q, smp_n;
  logic          rstp_q, rstp_n;
  logic          pull_q, pull_n;
  logic          brst_q, brst_n;
  logic          done_q, done_n;
  logic          bstb_q, bstb_n;
  logic          bval_q, bval_n;
  logic          rst_hit;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign rst_hit = rstp_q || (cnt_q >= t_reset);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    mode_n = mode_q;
    wr_n   = wr_q;
    drv0_n = drv0_q;
    smp_n  = smp_q;
    rstp_n = rstp_q;
    brst_n = 1'b0;
    done_n = 1'b0;
    bstb_n = 1'b0;
    bval_n = bval_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!line_s) begin
          st_n   = ST_LOW;
          cnt_n  = '0;
          mode_n = od_mode;
          wr_n   = !tx_mode;
          drv0_n = tx_mode && !tx_bit;
          smp_n  = 1'b1;
          rstp_n = 1'b0;
        end
      end
      ST_LOW: begin
        cnt_n = cnt_inc;
        if (cnt_q == t_sample) smp_n = line_s;
        if (cnt_q >= t_reset)  rstp_n = 1'b1;
        if (line_s && (cnt_q > t_sample)) begin
          cnt_n  = '0;
          drv0_n = 1'b0;
          if (rst_hit) begin
            st_n   = ST_PRES_WAIT;
            brst_n = 1'b1;
          end else begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
            bstb_n = wr_q;
            bval_n = smp_q;
          end
        end
      end
      ST_PRES_WAIT: begin
        cnt_n = cnt_inc;
        if (cnt_q >= t_pres_wait) begin
          st_n  = ST_PRES_LOW;
          cnt_n = '0;
        end
      end
      ST_PRES_LOW: begin
        cnt_n = cnt_inc;
        if (cnt_q >= t_pres_low) begin
          st_n  = ST_WAIT_HIGH;
          cnt_n = '0;
        end
      end
      ST_WAIT_HIGH: begin
        if (line_s) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    pull_n = (st_n == ST_PRES_LOW) ||
             ((st_n == ST_LOW) && drv0_n && (cnt_n < t_hold));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      wr_q   <= 1'b1;
      drv0_q <= 1'b0;
      smp_q  <= 1'b1;
      rstp_q <= 1'b0;
      pull_q <= 1'b0;
      brst_q <= 1'b0;
      done_q <= 1'b0;
      bstb_q <= 1'b0;
      bval_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      mode_q <= mode_n;
      wr_q   <= wr_n;
      drv0_q <= drv0_n;
      smp_q  <= smp_n;
      rstp_q <= rstp_n;
      pull_q <= pull_n;
      brst_q <= brst_n;
      done_q <= done_n;
      bstb_q <= bstb_n;
      if (bstb_n) bval_q <= bval_n;
    end
  end

  assign od_latched = mode_q;
  assign pull       = pull_q;
  assign bus_rst    = brst_q;
  assign slot_end   = done_q;
  assign bit_stb    = bstb_q;
  assign bit_val    = bval_q;
endmodule

// File: rtl/onewire_byte_asm.sv
module onewire_byte_asm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld
);
  localparam int BCW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BCW-1:0] LAST = BCW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BCW-1:0]    bc_q, bc_n;
  logic [BYTE_W-1:0] out_q, out_n;
  logic              vld_n, vld_q;

  always_comb begin
    sh_n  = sh_q;
    bc_n  = bc_q;
    out_n = out_q;
    vld_n = 1'b0;
    if (clr) begin
      bc_n = '0;
    end else if (bit_stb) begin
      // Each new bit enters at the top, so the first bit ends in bit 0.
      sh_n = {bit_val, sh_q[BYTE_W-1:1]};
      if (bc_q == LAST) begin
        bc_n  = '0;
        out_n = sh_n;
        vld_n = 1'b1;
      end else begin
        bc_n = bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bc_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      bc_q  <= bc_n;
      vld_q <= vld_n;
      if (vld_n) out_q <= out_n;
    end
  end

  assign byte_out = out_q;
  assign byte_vld = vld_q;
endmodule

// File: rtl/onewire_slave_phy.sv
module onewire_slave_phy #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int          SYNC_STAGES = 2,
  parameter int          BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dq_in,
  input  logic              od_mode,
  input  logic              tx_mode,
  input  logic              tx_bit,
  output logic              dq_pull,
  output logic              bus_reset,
  output logic              slot_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid
);
  import onewire_pkg::*;

  // The longest span any state counts is the standard reset threshold.
  localparam int CW = $clog2(tenths_to_cycles(CLK_HZ, 4800) + 2);

  logic          line_s;
  logic          od_lat;
  logic [CW-1:0] t_reset, t_pres_wait, t_pres_low, t_sample, t_hold;
  logic          bit_stb, bit_val;

  onewire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_raw  (dq_in),
    .d_sync (line_s)
  );

  onewire_timing #(.CLK_HZ(CLK_HZ), .CW(CW)) u_timing (
    .od_sel      (od_lat),
    .t_reset     (t_reset),
    .t_pres_wait (t_pres_wait),
    .t_pres_low  (t_pres_low),
    .t_sample    (t_sample),
    .t_hold      (t_hold)
  );

  onewire_slot_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_s      (line_s),
    .od_mode     (od_mode),
    .tx_mode     (tx_mode),
    .tx_bit      (tx_bit),
    .t_reset     (t_reset),
    .t_pres_wait (t_pres_wait),
    .t_pres_low  (t_pres_low),
    .t_sample    (t_sample),
    .t_hold      (t_hold),
    .od_latched  (od_lat),
    .pull        (dq_pull),
    .bus_rst     (bus_reset),
    .slot_end    (slot_done),
    .bit_stb     (bit_stb),
    .bit_val     (bit_val)
  );

  onewire_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bus_reset),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .byte_out (rx_byte),
    .byte_vld (rx_valid)
  );
endmodule

// File: rtl/onewire_slave_phy_chk.sv
module onewire_slave_phy_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dq_pull,
  input logic              bus_reset,
  input logic              slot_done,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_valid
);
  // R1: outputs stay quiet while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (!dq_pull && !bus_reset && !slot_done && !rx_valid);
    end
  end

  // R2: the reset indication lasts a single clock.
  p_reset_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);

  // R2: the line is released by the slave when a reset is reported.
  p_no_pull_at_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> !dq_pull);

  // R6: byte strobe lasts a single clock.
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: a byte completes only right after a finished slot.
  p_valid_after_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(slot_done));

  // R6: the presented byte moves only with its strobe.
  p_byte_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_valid);

  // R11: a reset is never reported as a bit slot.
  p_reset_not_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_reset && slot_done));
endmodule

bind onewire_slave_phy onewire_slave_phy_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dq_pull   (dq_pull),
  .bus_reset (bus_reset),
  .slot_done (slot_done),
  .rx_byte   (rx_byte),
  .rx_valid  (rx_valid)
);

// File: tb/onewire_slave_phy_tb_top.sv
module onewire_slave_phy_tb_top;
  localparam int CLK_HZ   = 50_000_000;
  localparam int CPU      = CLK_HZ / 1_000_000;
  localparam int WD_LIMIT = 196_000;

  typedef struct packed {
    logic       is_read;
    logic [7:0] data;
  } vec_t;

  // Overdrive vectors: writes check the assembled byte, reads check the host view.
  localparam vec_t VECS [7] = '{
    '{1'b0, 8'hA5}, '{1'b1, 8'h6C}, '{1'b0, 8'h00}, '{1'b0, 8'hFF},
    '{1'b1, 8'h01}, '{1'b0, 8'h81}, '{1'b1, 8'hFE}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic m_low;
  logic od_sel;
  logic tx_mode;
  logic tx_bit;
  logic dq_pull, bus_reset, slot_done, rx_valid;
  logic [7:0] rx_byte;
  wire  line = ~(m_low | dq_pull);

  int n_chk = 0;
  int n_fail = 0;
  int n_valid = 0;
  int n_rst = 0;
  int n_slot = 0;
  int cyc = 0;
  logic [7:0] last_byte = 8'h00;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  onewire_slave_phy #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dq_in     (line),
    .od_mode   (od_sel),
    .tx_mode   (tx_mode),
    .tx_bit    (tx_bit),
    .dq_pull   (dq_pull),
    .bus_reset (bus_reset),
    .slot_done (slot_done),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid)
  );

  always @(posedge clk) begin
    if (rx_valid) begin
      n_valid++;
      last_byte = rx_byte;
    end
    if (bus_reset) n_rst++;
    if (slot_done) n_slot++;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  function automatic int tu(input int tenths);
    return tenths * CPU / 10;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_bit(input bit b);
    int low, slot, rec;
    if (od_sel) begin low = b ? 10 : 80;  slot = 100; rec = 20; end
    else        begin low = b ? 50 : 650; slot = 800; rec = 50; end
    m_low = 1'b1;
    wait_cyc(tu(low));
    m_low = 1'b0;
    wait_cyc(tu(slot - low) + tu(rec));
  endtask

  task automatic rd_bit(input bit txb, output bit got);
    int smp, slot, rec;
    if (od_sel) begin smp = 15;  slot = 100; rec = 20; end
    else        begin smp = 100; slot = 800; rec = 50; end
    tx_mode = 1'b1;
    tx_bit  = txb;
    m_low   = 1'b1;
    wait_cyc(tu(10));
    m_low = 1'b0;
    wait_cyc(tu(smp - 10));
    got = line;
    wait_cyc(tu(slot - smp) + tu(rec));
    tx_mode = 1'b0;
    tx_bit  = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) wr_bit(b[i]);
  endtask

  task automatic rd_byte(input logic [7:0] b, output logic [7:0] got);
    bit g;
    for (int i = 0; i < 8; i++) begin
      rd_bit(b[i], g);
      got[i] = g;
    end
  endtask

  // Holds the line low, releases it, then measures the presence pull.
  task automatic bus_rst(input int low_tenths, output int pstart, output int plen);
    int window;
    window = od_sel ? 400 : 3200;
    m_low = 1'b1;
    wait_cyc(tu(low_tenths));
    m_low = 1'b0;
    pstart = -1;
    plen   = 0;
    for (int i = 0; i < tu(window); i++) begin
      @(negedge clk);
      if (dq_pull) begin
        if (pstart < 0) pstart = i;
        plen++;
      end
    end
  endtask

  initial begin
    int ps, pl, r0, v0, s0;
    bit g;
    logic [7:0] got;
    rst_n = 1'b1;
    m_low = 1'b0;
    od_sel = 1'b0;
    tx_mode = 1'b0;
    tx_bit = 1'b1;
    #3 rst_n = 1'b0;
    wait_cyc(5);
    chk(!dq_pull && !bus_reset && !slot_done && !rx_valid, "R1 outputs in reset",
        {dq_pull, bus_reset, slot_done, rx_valid}, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(!dq_pull && !rx_valid && n_slot == 0, "R1 outputs after reset",
        {dq_pull, rx_valid}, 0);

    // R2 / R3: standard reset and presence window.
    bus_rst(5000, ps, pl);
    chk(n_rst == 1, "R2 standard reset seen", n_rst, 1);
    chk(ps >= tu(150) && ps <= tu(600), "R3 presence start cycles", ps, tu(300));
    chk(pl >= tu(600) && pl <= tu(2400), "R3 presence length cycles", pl, tu(1200));

    // R5 / R6: standard write byte.
    v0 = n_valid;
    wr_byte(8'hC6);
    chk(n_valid == v0 + 1, "R6 standard byte strobe", n_valid, v0 + 1);
    chk(last_byte == 8'hC6, "R5 standard byte value", last_byte, 8'hC6);

    // R7: standard read slots.
    rd_bit(1'b0, g);
    chk(g == 1'b0, "R7 standard read zero", g, 0);
    rd_bit(1'b1, g);
    chk(g == 1'b1, "R7 standard read one", g, 1);

    // R2 / R10: 100 us pulse in standard mode is a bit, not a reset.
    r0 = n_rst; s0 = n_slot;
    m_low = 1'b1; wait_cyc(tu(1000)); m_low = 1'b0; wait_cyc(tu(200));
    chk(n_rst == r0, "R2 100us standard pulse not reset", n_rst, r0);
    chk(n_slot == s0 + 1, "R10 100us standard pulse is a slot", n_slot, s0 + 1);

    // R4: overdrive reset and presence window (also clears the stray bit).
    od_sel = 1'b1;
    wait_cyc(10);
    r0 = n_rst;
    bus_rst(1000, ps, pl);
    chk(n_rst == r0 + 1, "R4 R10 100us overdrive pulse is reset", n_rst, r0 + 1);
    chk(ps >= tu(20) && ps <= tu(60), "R4 presence start cycles", ps, tu(30));
    chk(pl >= tu(80) && pl <= tu(240), "R4 presence length cycles", pl, tu(120));

    // Vector table in overdrive.
    foreach (VECS[i]) begin
      v0 = n_valid; s0 = n_slot;
      if (!VECS[i].is_read) begin
        wr_byte(VECS[i].data);
        chk(n_valid == v0 + 1, "R6 overdrive byte strobe", n_valid, v0 + 1);
        chk(last_byte == VECS[i].data, "R5 R6 overdrive byte value", last_byte, VECS[i].data);
      end else begin
        rd_byte(VECS[i].data, got);
        chk(got == VECS[i].data, "R7 overdrive read byte", got, VECS[i].data);
        chk(n_valid == v0, "R8 read byte makes no strobe", n_valid, v0);
      end
      chk(n_slot == s0 + 8, "R11 eight slot pulses per byte", n_slot - s0, 8);
    end

    // R8: read slots inside a byte are skipped by the assembler.
    v0 = n_valid;
    for (int i = 0; i < 4; i++) wr_bit(i[0] ? 1'b1 : 1'b0);
    rd_byte(8'h00, got);
    for (int i = 4; i < 8; i++) wr_bit(i[0] ? 1'b0 : 1'b1);
    chk(n_valid == v0 + 1, "R8 one byte around reads", n_valid, v0 + 1);
    chk(last_byte == 8'h5A, "R8 byte around reads", last_byte, 8'h5A);

    // R9: partial byte dropped by a reset.
    wr_bit(1'b1); wr_bit(1'b1); wr_bit(1'b1);
    v0 = n_valid;
    bus_rst(600, ps, pl);
    wr_byte(8'h3C);
    chk(n_valid == v0 + 1, "R9 single byte after reset", n_valid, v0 + 1);
    chk(last_byte == 8'h3C, "R9 byte realigned after reset", last_byte, 8'h3C);

    // R10: mode is latched at the falling edge.
    r0 = n_rst;
    m_low = 1'b1;
    wait_cyc(tu(100));
    od_sel = 1'b0;
    wait_cyc(tu(500));
    m_low = 1'b0;
    wait_cyc(tu(400));
    chk(n_rst == r0 + 1, "R10 mode latched at falling edge", n_rst, r0 + 1);

    summary();
  end
endmodule